// File: doc/BRIEF.md
# Serial Configuration Port with Control-Mode Latch

This block gives a converter's configuration space a small serial slave on three pins: a chip select, a serial clock and one bidirectional data line. After reset the three pins are treated as plain static control levels, which the block hands on to the surrounding logic. The first time chip select is seen low, the block switches for good into serial mode. From then on each chip-select-low period carries one transfer. A transfer has a 16-bit header: a direction flag, a two-bit byte count and a 13-bit register address. One to four data bytes follow, and the block writes them into, or reads them out of, a register file of 32 bytes.

All three pins are brought into a fast system clock through two-flop synchronisers, and serial clock edges are found in that domain. The register file is exposed as one flat output vector for the controlled logic. During reads the block drives the data line and raises an output enable. It changes read data only after a serial clock fall, so a master that samples on the rising edge sees settled bits.

Top module: `cfg_spi_slave`

## Requirements
- R1: After reset `serial_mode` is 0, `sdio_oe` is 0 and every register byte on `reg_flat` is 0x00.
- R2: While `serial_mode` is 0 and chip select is high, `pin_ctl` follows the synchronised pin levels with bit 2 = data line, bit 1 = chip select, bit 0 = serial clock. Serial clock toggles change no register.
- R3: The first chip-select-low sets `serial_mode` to 1. It stays 1 until reset, and `pin_ctl` is then frozen.
- R4: The header is 16 bits, sent MSB first and sampled on the rising serial clock: bit 15 is the direction (1 = read, 0 = write), bits 14:13 hold the byte count minus one, and bits 12:0 hold the start address.
- R5: Write data bytes arrive MSB first. Each complete byte is stored at the current address, and the address then increments by one. Bytes after the counted number are ignored.
- R6: In a read, the block raises `sdio_oe` and presents the register byte MSB first. It updates `sdio_out` only after a falling serial clock edge, beginning with the first fall after the header. It drops `sdio_oe` once the counted bytes are sent.
- R7: Chip select going high ends the transfer at once. A partly received byte is discarded and `sdio_oe` falls. If chip select rises at the same rising serial clock edge that would complete a byte, that byte is discarded too. The next low starts a fresh header.
- R8: Only addresses 0x0000 to 0x001F hold registers. Writes elsewhere change nothing, and reads elsewhere return 0x00.
- R9: Register n appears on `reg_flat[8n+7:8n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low in serial mode |
| sclk_pin | input | 1 | Serial clock pin |
| sdio_in | input | 1 | Data line, input side |
| sdio_out | output | 1 | Data line, output side |
| sdio_oe | output | 1 | Drive enable for the data line |
| serial_mode | output | 1 | 1 once serial control has been entered |
| pin_ctl | output | 3 | Static levels {data, select, clock} from pin-control mode |
| reg_flat | output | 256 | All register bytes, register n at bits 8n+7:8n |

## Verification
Two things can land in the same system cycle: the end of a transfer caused by chip select going high, and the rising serial clock edge that completes a data byte. Both pins pass through synchronisers of equal depth. The bench provokes the collision by raising chip select and the serial clock together on the eighth bit of a write byte, so both events reach the engine in one cycle. The test passes if that register keeps its old value and a following normal transfer still decodes its header correctly. Separate sweeps then check burst lengths one to four at start addresses near the top of the register range, along with reads and writes past it.

// File: rtl/cfg_spi_pkg.sv
// Shared constants and types for the serial configuration port.
// Assumes a 16-bit header: direction, two-bit count, 13-bit address.
package cfg_spi_pkg;
    localparam int ADDR_W = 13;
    localparam int HDR_W  = 16;
    localparam int CNT_W  = 2;

    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_WR   = 2'd1,
        PH_RD   = 2'd2,
        PH_DONE = 2'd3
    } phase_t;
endpackage

// File: rtl/cfg_spi_sync.sv
// Two-flop synchroniser for a bundle of asynchronous pins, plus rise and
// fall detection on bit 0. Assumes the system clock is fast enough that
// every pin level lasts at least two system cycles.
module cfg_spi_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         rise0,
    output logic         fall0
);
    logic [W-1:0] stage2;
    logic         prev0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic stage1;
        // two-stage capture of pin i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1    <= RST_VAL[i];
                stage2[i] <= RST_VAL[i];
            end else begin
                stage1    <= d[i];
                stage2[i] <= stage1;
            end
        end
    end

    // delayed copy of bit 0 for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev0 <= RST_VAL[0];
        else        prev0 <= stage2[0];
    end

    assign q     = stage2;
    assign rise0 = stage2[0] & ~prev0;
    assign fall0 = ~stage2[0] & prev0;
endmodule

// File: rtl/cfg_spi_mode.sv
// Control-mode latch: hands on static pin levels until chip select is first
// seen low, then locks into serial mode until reset.
// Assumes cs_s is the synchronised, active-low chip select.
module cfg_spi_mode (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_s,
    input  logic [2:0] lvl,
    output logic       serial_mode,
    output logic [2:0] pin_ctl
);
    // sticky mode flag and level hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serial_mode <= 1'b0;
            pin_ctl     <= 3'b000;
        end else begin
            if (!cs_s) serial_mode <= 1'b1;
            if (!serial_mode && cs_s) pin_ctl <= lvl;
        end
    end

    // R2
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode && cs_s) |=> !serial_mode);
    // R3
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode |=> serial_mode);
    // R3
    pin_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode |=> $stable(pin_ctl));
endmodule

// File: rtl/cfg_spi_engine.sv
// Transfer engine: decodes the header, counts bits and bytes, increments the
// address, holds the register file and drives the data line on reads.
// Assumes synchronised inputs and single-cycle serial clock edge strobes.
module cfg_spi_engine
    import cfg_spi_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_s,
    input  logic            sclk_rise,
    input  logic            sclk_fall,
    input  logic            sdi,
    output logic            sdo,
    output logic            sdo_oe,
    output logic [NREG*8-1:0] regs_o
);
    localparam int IW = $clog2(NREG);

    phase_t              phase;
    logic [3:0]          hdr_cnt;
    logic [HDR_W-2:0]    hdr_sh;
    logic [2:0]          bit_i;
    logic [CNT_W-1:0]    left;
    logic [ADDR_W-1:0]   addr;
    logic [6:0]          rx_sh;
    logic [7:0]          tx_sh;
    logic [7:0]          regs [NREG];
    logic [HDR_W-1:0]    hdr_full;
    logic [ADDR_W-1:0]   addr_nx;

    assign hdr_full = {hdr_sh, sdi};
    assign addr_nx  = addr + 1'b1;

    function automatic logic [7:0] rd_byte(input logic [ADDR_W-1:0] a);
        if (a < ADDR_W'(NREG)) return regs[a[IW-1:0]];
        return 8'h00;
    endfunction

    // transfer sequencing, register writes and read shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_HDR;
            hdr_cnt <= '0;
            hdr_sh  <= '0;
            bit_i   <= '0;
            left    <= '0;
            addr    <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
            for (int k = 0; k < NREG; k++) regs[k] <= 8'h00;
        end else if (cs_s) begin
            phase   <= PH_HDR;
            hdr_cnt <= '0;
            bit_i   <= '0;
            sdo_oe  <= 1'b0;
        end else begin
            case (phase)
                PH_HDR: if (sclk_rise) begin
                    hdr_sh  <= {hdr_sh[HDR_W-3:0], sdi};
                    hdr_cnt <= hdr_cnt + 1'b1;
                    if (hdr_cnt == 4'(HDR_W - 1)) begin
                        addr  <= hdr_full[ADDR_W-1:0];
                        left  <= hdr_full[HDR_W-2 -: CNT_W];
                        bit_i <= '0;
                        if (hdr_full[HDR_W-1]) begin
                            phase <= PH_RD;
                            tx_sh <= rd_byte(hdr_full[ADDR_W-1:0]);
                        end else begin
                            phase <= PH_WR;
                        end
                    end
                end
                PH_WR: if (sclk_rise) begin
                    rx_sh <= {rx_sh[5:0], sdi};
                    bit_i <= bit_i + 1'b1;
                    if (bit_i == 3'd7) begin
                        if (addr < ADDR_W'(NREG)) regs[addr[IW-1:0]] <= {rx_sh, sdi};
                        addr <= addr_nx;
                        if (left == '0) phase <= PH_DONE;
                        else            left  <= left - 1'b1;
                    end
                end
                PH_RD: begin
                    if (sclk_fall) begin
                        sdo    <= tx_sh[7];
                        tx_sh  <= {tx_sh[6:0], 1'b0};
                        sdo_oe <= 1'b1;
                    end else if (sclk_rise) begin
                        bit_i <= bit_i + 1'b1;
                        if (bit_i == 3'd7) begin
                            addr  <= addr_nx;
                            tx_sh <= rd_byte(addr_nx);
                            if (left == '0) begin
                                phase  <= PH_DONE;
                                sdo_oe <= 1'b0;
                            end else begin
                                left <= left - 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar n = 0; n < NREG; n++) begin : g_out
        assign regs_o[8*n +: 8] = regs[n];
    end

    // R6
    oe_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (phase == PH_RD));
    // R6
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdo));
    // R7
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (!sdo_oe && phase == PH_HDR));
    // R8
    range_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && phase == PH_WR && sclk_rise && bit_i == 3'd7 && addr >= ADDR_W'(NREG))
        |=> $stable(regs_o));
endmodule

// File: rtl/cfg_spi_slave.sv
// Top level of the serial configuration port: pin synchronisers, the
// control-mode latch and the transfer engine.
// Assumes clk runs at least 8x the serial clock; reset is synchronous.
module cfg_spi_slave #(
    parameter int NREG = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_pin,
    input  logic              sclk_pin,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              serial_mode,
    output logic [2:0]        pin_ctl,
    output logic [NREG*8-1:0] reg_flat
);
    logic [2:0] lvl;
    logic       sclk_rise;
    logic       sclk_fall;

    cfg_spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sdio_in, cs_n_pin, sclk_pin}),
        .q     (lvl),
        .rise0 (sclk_rise),
        .fall0 (sclk_fall)
    );

    cfg_spi_mode u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (lvl[1]),
        .lvl         (lvl),
        .serial_mode (serial_mode),
        .pin_ctl     (pin_ctl)
    );

    cfg_spi_engine #(.NREG(NREG)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (lvl[1]),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi       (lvl[2]),
        .sdo       (sdio_out),
        .sdo_oe    (sdio_oe),
        .regs_o    (reg_flat)
    );
endmodule

// File: tb/cfg_spi_slave_test.sv
module cfg_spi_slave_test;
    localparam int NREG = 32;
    localparam int H    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n_pin = 1'b1, sclk_pin = 1'b0, sdio_in = 1'b0;
    logic sdio_out, sdio_oe, serial_mode;
    logic [2:0] pin_ctl;
    logic [NREG*8-1:0] reg_flat;

    int total = 0, fails = 0;
    logic [7:0] model [NREG];
    logic last_oe;
    logic oe_seen_all;
    logic oe_at_end;

    always #2 clk = ~clk;

    cfg_spi_slave #(.NREG(NREG)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic got);
        sdio_in = b;
        repeat (H) @(negedge clk);
        got = sdio_out;
        last_oe = sdio_oe;
        sclk_pin = 1'b1;
        repeat (H) @(negedge clk);
        sclk_pin = 1'b0;
    endtask

    // n = header count, nsend = data bytes actually clocked
    task automatic xfer(input logic rd, input int n, input int nsend,
                        input logic [12:0] a, input logic [31:0] wd,
                        output logic [31:0] rdv);
        logic [15:0] hdr;
        logic g;
        rdv = '0;
        oe_seen_all = 1'b1;
        cs_n_pin = 1'b0;
        repeat (H) @(negedge clk);
        hdr = {rd, 2'(n - 1), a};
        for (int i = 15; i >= 0; i--) sbit(hdr[i], g);
        for (int k = 0; k < nsend; k++)
            for (int b = 7; b >= 0; b--) begin
                sbit(rd ? 1'b0 : wd[8*k + b], g);
                rdv[8*k + b] = g;
                if (rd) oe_seen_all &= last_oe;
            end
        repeat (H) @(negedge clk);
        oe_at_end = sdio_oe;
        cs_n_pin = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        return (a < NREG) ? model[a] : 8'h00;
    endfunction

    task automatic check_regs(input string req);
        for (int a = 0; a < NREG; a++) chk(req, reg_flat[8*a +: 8], model[a]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] rdv, wd;
        logic g;
        for (int a = 0; a < NREG; a++) model[a] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 mode", serial_mode, 0);
        chk("R1 oe", sdio_oe, 0);
        check_regs("R1 regs");

        // R2 pin-control: sweep clock/data levels with select high
        for (int p = 0; p < 4; p++) begin
            sdio_in = p[1]; sclk_pin = p[0];
            repeat (6) @(negedge clk);
            chk("R2 pin_ctl", pin_ctl, {p[1], 1'b1, p[0]});
            chk("R2 mode", serial_mode, 0);
        end
        for (int t = 0; t < 6; t++) begin
            sclk_pin = ~sclk_pin; repeat (6) @(negedge clk);
        end
        check_regs("R2 no write");
        sdio_in = 1'b1; sclk_pin = 1'b0;
        repeat (6) @(negedge clk);

        // R3 R4 R5 R9: fill all registers in 4-byte bursts
        for (int blk = 0; blk < NREG / 4; blk++) begin
            wd = '0;
            for (int k = 0; k < 4; k++) begin
                wd[8*k +: 8] = 8'((blk*4 + k) * 37 + 5);
                model[blk*4 + k] = wd[8*k +: 8];
            end
            xfer(1'b0, 4, 4, 13'(blk*4), wd, rdv);
            if (blk == 0) chk("R3 mode set", serial_mode, 1);
        end
        check_regs("R5 R9 burst write");
        chk("R3 pin frozen", pin_ctl, 3'b110);
        sdio_in = 1'b0; sclk_pin = 1'b1; repeat (8) @(negedge clk);
        chk("R3 pin frozen after toggle", pin_ctl, 3'b110);
        sclk_pin = 1'b0; repeat (8) @(negedge clk);
        chk("R3 mode sticky", serial_mode, 1);

        // R5 extra bytes beyond count ignored
        model[2] = 8'h3C;
        xfer(1'b0, 1, 2, 13'd2, 32'h0000_C33C, rdv);
        check_regs("R5 count limit");

        // R8 write running past the top
        model[30] = 8'h11; model[31] = 8'h22;
        xfer(1'b0, 4, 4, 13'd30, 32'h4433_2211, rdv);
        check_regs("R8 write past top");
        xfer(1'b0, 2, 2, 13'h1000, 32'h0000_BEEF, rdv);
        check_regs("R8 write out of range");

        // R4 R6 R8: read sweep over counts and start addresses
        for (int n = 1; n <= 4; n++) begin
            for (int s = 0; s < 6; s++) begin
                int st;
                st = (s == 0) ? 0 : (s == 1) ? 7 : (s == 2) ? 13 :
                     (s == 3) ? 29 : (s == 4) ? 31 : 4096;
                xfer(1'b1, n, n, 13'(st), 32'h0, rdv);
                for (int k = 0; k < n; k++)
                    chk("R6 R8 read data", rdv[8*k +: 8], exp_rd(st + k));
                chk("R6 oe during read", oe_seen_all, 1);
                chk("R6 oe released", oe_at_end, 0);
            end
        end

        // R7 abort mid-byte
        cs_n_pin = 1'b0; repeat (H) @(negedge clk);
        for (int i = 15; i >= 0; i--) sbit(16'h0005 >> i, g);
        for (int b = 0; b < 5; b++) sbit(1'b1, g);
        cs_n_pin = 1'b1; repeat (12) @(negedge clk);
        check_regs("R7 partial byte");

        // R7 abort read: enable drops
        cs_n_pin = 1'b0; repeat (H) @(negedge clk);
        for (int i = 15; i >= 0; i--) sbit(16'h8003 >> i, g);
        for (int b = 0; b < 3; b++) sbit(1'b0, g);
        chk("R7 oe mid read", sdio_oe, 1);
        cs_n_pin = 1'b1; repeat (6) @(negedge clk);
        chk("R7 oe after abort", sdio_oe, 0);
        repeat (6) @(negedge clk);

        // R7 select rise in the same edge as the final bit of a byte
        cs_n_pin = 1'b0; repeat (H) @(negedge clk);
        for (int i = 15; i >= 0; i--) sbit(16'h0006 >> i, g);
        for (int b = 0; b < 7; b++) sbit(1'b1, g);
        sdio_in = 1'b1; repeat (H) @(negedge clk);
        sclk_pin = 1'b1; cs_n_pin = 1'b1;
        repeat (H) @(negedge clk);
        sclk_pin = 1'b0; repeat (12) @(negedge clk);
        check_regs("R7 same-edge abort");

        // R7 next transfer decodes a fresh header
        model[7] = 8'hA5;
        xfer(1'b0, 1, 1, 13'd7, 32'h0000_00A5, rdv);
        check_regs("R7 new header");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule